// File: doc/BRIEF.md
# Keyed Diagnostic Register Unlock

This block is a small register file that protects a diagnostic control register behind a fixed six-word key. A host on a simple synchronous register bus must write the key words one after another to a dedicated key register. Until the whole key has arrived in order, the block ignores every write to the diagnostic control register. When the key matches, a write-enabled flag in the diagnostic register reads back as 1.

After unlocking, the host sets a separate window-enable bit. This opens an indirect window into a 32-bit internal address space, modelled here as a small on-chip word memory. The host writes an upper address word and then a lower address word. A read of the data register then returns the addressed word, and a write to it stores one.

The diagnostic register also drives the reset controls: a hold-in-reset level, a boot-source select and a force-host-boot level. It also has a self-clearing adapter-reset trigger. A triggered adapter reset asserts a reset output for a fixed number of cycles, records reset history and locks the block again.

Top module: `keyed_diag_regs`

## Requirements
- R1: Writing 0x00, 0x04, 0x0B, 0x02, 0x07 and 0x0D to the key register (offset 0) in that order unlocks the block, after which bit 7 of the diagnostic register (offset 1) reads 1. Once unlocked, the block stays unlocked until an adapter reset.
- R2: A key word that does not match the expected step restarts matching. If that word equals 0x00, it counts as step one of a new attempt. A wrong final word leaves the block locked.
- R3: While locked, writes to the diagnostic register have no effect on any of its fields or on the reset-control outputs.
- R4: The window is open only when the block is unlocked and bit 4 of the diagnostic register is 1. While the window is closed, reads of the data register (offset 4) return 0 and writes to it are dropped.
- R5: With the window open, the upper address (offset 2) and lower address (offset 3) select a byte address, of which bits 1:0 are ignored. A data write stores the word, and a data read returns it. An address with a nonzero upper word, or a lower word at or beyond MEM_WORDS*4, reads 0 and drops writes.
- R6: Writing 1 to bit 2 of the diagnostic register while unlocked asserts adapter_rst_o for exactly RST_CYCLES cycles starting on the next cycle. It also sets bit 5 (reset history), clears bit 4 and locks the block.
- R7: Bit 1 drives hold_rst_o, bits 12:11 drive boot_sel_o (00 default, 01 host memory), and bit 9 drives force_hostboot_o. Bit 8 reads 1 when bit 9 is 1 or bits 12:11 are 01.
- R8: Bit 6 (flash-bad flag) is 1 after reset. Writing 1 to bit 10 while unlocked clears it for good. Bit 10 always reads 0. While unlocked, an ordinary write loads bit 5 from the written value.
- R9: Read data appears on bus_rdata the cycle after bus_rd is sampled high and holds until the next read. Key register reads return 0.
- R10: After reset the block is locked, the diagnostic register reads 0x40, and all reset-control outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | BUS_AW | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| adapter_rst_o | output | 1 | Adapter reset pulse |
| hold_rst_o | output | 1 | Hold internal processor in reset |
| boot_sel_o | output | 2 | Boot source select |
| force_hostboot_o | output | 1 | Force host-boot mode |

## Verification
The assertions assume that read and write strobes never occur in the same cycle and that the strobes carry no X after reset. They also assume that a data write and an address write never share a cycle; the single-port bus makes this true. The bench drives each access for exactly one cycle with the other strobe low, and it returns both strobes to 0 between accesses. Relock is checked across a pulse in which the host stays silent, so the key matcher starts the next attempt from a known empty state.

// File: rtl/kdr_pkg.sv
package kdr_pkg;

    localparam int unsigned KEY_LEN = 6;

    typedef logic [31:0] word_t;

    typedef enum logic [2:0] {
        REG_KEY  = 3'd0,
        REG_DIAG = 3'd1,
        REG_AHI  = 3'd2,
        REG_ALO  = 3'd3,
        REG_DATA = 3'd4
    } reg_sel_e;

    // diagnostic register bit positions
    localparam int unsigned B_HOLD   = 1;
    localparam int unsigned B_RSTADP = 2;
    localparam int unsigned B_WINEN  = 4;
    localparam int unsigned B_HIST   = 5;
    localparam int unsigned B_FBAD   = 6;
    localparam int unsigned B_WREN   = 7;
    localparam int unsigned B_HBIND  = 8;
    localparam int unsigned B_FORCE  = 9;
    localparam int unsigned B_FBCLR  = 10;
    localparam int unsigned B_BOOTLO = 11;

    typedef struct packed {
        logic [1:0] boot_sel;
        logic       force_hb;
        logic       win_en;
        logic       hist;
        logic       flash_bad;
        logic       hold;
    } diag_ctrl_t;

    function automatic word_t key_value(input logic [2:0] idx);
        case (idx)
            3'd0:    key_value = 32'h0000_0000;
            3'd1:    key_value = 32'h0000_0004;
            3'd2:    key_value = 32'h0000_000B;
            3'd3:    key_value = 32'h0000_0002;
            3'd4:    key_value = 32'h0000_0007;
            default: key_value = 32'h0000_000D;
        endcase
    endfunction

    function automatic word_t diag_pack(input diag_ctrl_t c, input logic unl);
        word_t v;
        v = '0;
        v[B_HOLD]            = c.hold;
        v[B_WINEN]           = c.win_en;
        v[B_HIST]            = c.hist;
        v[B_FBAD]            = c.flash_bad;
        v[B_WREN]            = unl;
        v[B_HBIND]           = c.force_hb | (c.boot_sel == 2'b01);
        v[B_FORCE]           = c.force_hb;
        v[B_BOOTLO +: 2]     = c.boot_sel;
        return v;
    endfunction

endpackage

// File: rtl/key_seq_matcher.sv
module key_seq_matcher
    import kdr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  key_wr,
    input  word_t key_data,
    input  logic  relock,
    output logic  unlocked
);
    localparam int unsigned STEP_W = 3;

    logic [STEP_W-1:0] step;
    logic              hit;
    logic              restart_hit;

    assign hit         = (key_data == key_value(step));
    assign restart_hit = (key_data == key_value(3'd0));

    always_ff @(posedge clk) begin
        if (rst || relock) begin
            step     <= '0;
            unlocked <= 1'b0;
        end else if (key_wr && !unlocked) begin
            if (hit) begin
                if (step == STEP_W'(KEY_LEN - 1)) begin
                    unlocked <= 1'b1;
                    step     <= '0;
                end else begin
                    step <= step + 1'b1;
                end
            end else if (restart_hit) begin
                step <= STEP_W'(1);
            end else begin
                step <= '0;
            end
        end
    end

    assert_stay_unlocked_R1: assert property (@(posedge clk) disable iff (rst)
        unlocked && !relock |=> unlocked);
    assert_unlock_needs_key_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(key_wr));
    assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
        key_wr && !unlocked && !relock && !hit && !restart_hit |=> (step == '0) && !unlocked);
    assert_relock_R6: assert property (@(posedge clk) disable iff (rst)
        relock |=> !unlocked);

endmodule

// File: rtl/diag_ctrl.sv
module diag_ctrl
    import kdr_pkg::*;
#(
    parameter int unsigned RST_CYCLES     = 8,
    parameter bit          FLASH_BAD_INIT = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       unlocked,
    input  logic       diag_wr,
    input  word_t      wdata,
    output diag_ctrl_t ctrl,
    output logic       adapter_rst,
    output logic       relock
);
    localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             accept;

    assign accept      = diag_wr && unlocked;
    assign relock      = accept && wdata[B_RSTADP];
    assign adapter_rst = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl           <= '0;
            ctrl.flash_bad <= FLASH_BAD_INIT;
            cnt            <= '0;
        end else begin
            if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (accept) begin
                ctrl.hold     <= wdata[B_HOLD];
                ctrl.win_en   <= wdata[B_WINEN];
                ctrl.hist     <= wdata[B_HIST];
                ctrl.force_hb <= wdata[B_FORCE];
                ctrl.boot_sel <= wdata[B_BOOTLO +: 2];
                if (wdata[B_FBCLR]) begin
                    ctrl.flash_bad <= 1'b0;
                end
                if (wdata[B_RSTADP]) begin
                    cnt         <= CNT_W'(RST_CYCLES);
                    ctrl.hist   <= 1'b1;
                    ctrl.win_en <= 1'b0;
                end
            end
        end
    end

    assert_locked_ignore_R3: assert property (@(posedge clk) disable iff (rst)
        diag_wr && !unlocked |=> $stable(ctrl));
    assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        relock |=> adapter_rst && ctrl.hist && !ctrl.win_en);
    assert_flash_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        !ctrl.flash_bad |=> !ctrl.flash_bad);

endmodule

// File: rtl/diag_window.sv
module diag_window
    import kdr_pkg::*;
#(
    parameter int unsigned MEM_WORDS = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  open,
    input  logic  ahi_wr,
    input  logic  alo_wr,
    input  logic  data_wr,
    input  word_t wdata,
    output word_t addr_hi,
    output word_t addr_lo,
    output word_t rd_word
);
    localparam int unsigned IDX_W = $clog2(MEM_WORDS);
    localparam word_t       LIMIT = word_t'(MEM_WORDS * 4);

    word_t            mem [MEM_WORDS];
    logic [IDX_W-1:0] idx;
    logic             in_range;

    assign idx      = addr_lo[IDX_W+1:2];
    assign in_range = (addr_hi == '0) && (addr_lo < LIMIT);
    assign rd_word  = (open && in_range) ? mem[idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_hi <= '0;
            addr_lo <= '0;
        end else begin
            if (ahi_wr) addr_hi <= wdata;
            if (alo_wr) addr_lo <= wdata;
        end
    end

    for (genvar g = 0; g < MEM_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (data_wr && open && in_range && (idx == IDX_W'(g))) begin
                mem[g] <= wdata;
            end
        end
    end

    assert_store_R5: assert property (@(posedge clk) disable iff (rst)
        data_wr && open && in_range && !ahi_wr && !alo_wr |=> rd_word == $past(wdata));

endmodule

// File: rtl/keyed_diag_regs.sv
module keyed_diag_regs
    import kdr_pkg::*;
#(
    parameter int unsigned BUS_AW         = 3,
    parameter int unsigned MEM_WORDS      = 16,
    parameter int unsigned RST_CYCLES     = 8,
    parameter bit          FLASH_BAD_INIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              adapter_rst_o,
    output logic              hold_rst_o,
    output logic [1:0]        boot_sel_o,
    output logic              force_hostboot_o
);
    logic       sel_key, sel_diag, sel_ahi, sel_alo, sel_data;
    logic       unlocked, relock, win_open;
    diag_ctrl_t ctrl;
    word_t      addr_hi, addr_lo, win_word, rd_mux;

    assign sel_key  = (bus_addr == BUS_AW'(REG_KEY));
    assign sel_diag = (bus_addr == BUS_AW'(REG_DIAG));
    assign sel_ahi  = (bus_addr == BUS_AW'(REG_AHI));
    assign sel_alo  = (bus_addr == BUS_AW'(REG_ALO));
    assign sel_data = (bus_addr == BUS_AW'(REG_DATA));
    assign win_open = unlocked && ctrl.win_en;

    key_seq_matcher u_key (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (bus_wr && sel_key),
        .key_data (bus_wdata),
        .relock   (relock),
        .unlocked (unlocked)
    );

    diag_ctrl #(
        .RST_CYCLES     (RST_CYCLES),
        .FLASH_BAD_INIT (FLASH_BAD_INIT)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .unlocked    (unlocked),
        .diag_wr     (bus_wr && sel_diag),
        .wdata       (bus_wdata),
        .ctrl        (ctrl),
        .adapter_rst (adapter_rst_o),
        .relock      (relock)
    );

    diag_window #(
        .MEM_WORDS (MEM_WORDS)
    ) u_win (
        .clk     (clk),
        .rst     (rst),
        .open    (win_open),
        .ahi_wr  (bus_wr && sel_ahi),
        .alo_wr  (bus_wr && sel_alo),
        .data_wr (bus_wr && sel_data),
        .wdata   (bus_wdata),
        .addr_hi (addr_hi),
        .addr_lo (addr_lo),
        .rd_word (win_word)
    );

    always_comb begin
        rd_mux = '0;
        if (sel_diag) rd_mux = diag_pack(ctrl, unlocked);
        if (sel_ahi)  rd_mux = addr_hi;
        if (sel_alo)  rd_mux = addr_lo;
        if (sel_data) rd_mux = win_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assign hold_rst_o       = ctrl.hold;
    assign boot_sel_o       = ctrl.boot_sel;
    assign force_hostboot_o = ctrl.force_hb;

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
    assert_closed_read_R4: assert property (@(posedge clk) disable iff (rst)
        bus_rd && sel_data && !win_open |=> bus_rdata == '0);

endmodule

// File: tb/keyed_diag_regs_tb.sv
`timescale 1ns/1ps
module keyed_diag_regs_tb;
    localparam int RSTC = 8;
    localparam int MEMW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  baddr = '0;
    logic [31:0] bwd = '0;
    logic        bwr = 1'b0;
    logic        brd = 1'b0;
    logic [31:0] rdata;
    logic        arst, hold, force_hb;
    logic [1:0]  boot;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    keyed_diag_regs #(.BUS_AW(3), .MEM_WORDS(MEMW), .RST_CYCLES(RSTC), .FLASH_BAD_INIT(1'b1)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(baddr), .bus_wdata(bwd), .bus_wr(bwr), .bus_rd(brd),
        .bus_rdata(rdata), .adapter_rst_o(arst), .hold_rst_o(hold),
        .boot_sel_o(boot), .force_hostboot_o(force_hb)
    );

    // ---------------- behavioural reference model ----------------
    int          m_step, m_unl, m_cnt;
    int          m_hold, m_win, m_hist, m_fbad, m_force, m_boot;
    logic [31:0] m_ahi, m_alo, m_rdata;
    logic [31:0] m_mem [MEMW];
    int          keyq [$] = '{32'h0, 32'h4, 32'hB, 32'h2, 32'h7, 32'hD};

    function automatic logic [31:0] m_diag();
        logic [31:0] v = 0;
        v |= m_hold  ? 32'h2   : 0;
        v |= m_win   ? 32'h10  : 0;
        v |= m_hist  ? 32'h20  : 0;
        v |= m_fbad  ? 32'h40  : 0;
        v |= m_unl   ? 32'h80  : 0;
        v |= (m_force || m_boot == 1) ? 32'h100 : 0;
        v |= m_force ? 32'h200 : 0;
        v |= 32'(m_boot) << 11;
        return v;
    endfunction

    function automatic bit m_hit();
        return (m_ahi == 0) && (m_alo < MEMW * 4);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_step <= 0; m_unl <= 0; m_cnt <= 0;
            m_hold <= 0; m_win <= 0; m_hist <= 0; m_fbad <= 1; m_force <= 0; m_boot <= 0;
            m_ahi <= 0; m_alo <= 0; m_rdata <= 0;
            for (int i = 0; i < MEMW; i++) m_mem[i] <= 0;
        end else begin
            if (m_cnt > 0) m_cnt <= m_cnt - 1;
            if (brd) begin
                case (baddr)
                    3'd1: m_rdata <= m_diag();
                    3'd2: m_rdata <= m_ahi;
                    3'd3: m_rdata <= m_alo;
                    3'd4: m_rdata <= (m_unl && m_win && m_hit()) ? m_mem[m_alo[5:2]] : 0;
                    default: m_rdata <= 0;
                endcase
            end
            if (bwr) begin
                case (baddr)
                    3'd0: if (!m_unl) begin
                        if (bwd == keyq[m_step]) begin
                            if (m_step == 5) begin m_unl <= 1; m_step <= 0; end
                            else m_step <= m_step + 1;
                        end else m_step <= (bwd == keyq[0]) ? 1 : 0;
                    end
                    3'd1: if (m_unl) begin
                        m_hold <= bwd[1]; m_win <= bwd[4]; m_hist <= bwd[5];
                        m_force <= bwd[9]; m_boot <= int'(bwd[12:11]);
                        if (bwd[10]) m_fbad <= 0;
                        if (bwd[2]) begin
                            m_cnt <= RSTC; m_hist <= 1; m_win <= 0; m_unl <= 0; m_step <= 0;
                        end
                    end
                    3'd2: m_ahi <= bwd;
                    3'd3: m_alo <= bwd;
                    3'd4: if (m_unl && m_win && m_hit()) m_mem[m_alo[5:2]] <= bwd;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R9 rdata", rdata, m_rdata);
            chk("R6 adapter_rst", 32'(arst), 32'(m_cnt > 0));
            chk("R7 hold", 32'(hold), 32'(m_hold));
            chk("R7 boot", 32'(boot), 32'(m_boot));
            chk("R7 force", 32'(force_hb), 32'(m_force));
        end
    end

    task automatic bus_w(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); baddr = a; bwd = d; bwr = 1'b1;
        @(negedge clk); bwr = 1'b0;
    endtask

    task automatic bus_r(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); baddr = a; brd = 1'b1;
        @(negedge clk); brd = 1'b0; d = rdata;
    endtask

    task automatic send_key(input logic [31:0] last);
        bus_w(0, 32'h0); bus_w(0, 32'h4); bus_w(0, 32'hB);
        bus_w(0, 32'h2); bus_w(0, 32'h7); bus_w(0, last);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 adapter_rst low", 32'(arst), 0);
        chk("R10 hold/boot/force low", {29'b0, hold, boot} | 32'(force_hb), 0);
        bus_r(1, v); chk("R10 diag reset value", v, 32'h40);
        // R4 locked data read
        bus_r(4, v); chk("R4 locked data read", v, 0);
        // R3 locked diag write ignored
        bus_w(1, 32'h0A12);
        chk("R3 hold unchanged", 32'(hold), 0);
        bus_r(1, v); chk("R3 locked write ignored", v, 32'h40);
        // R2 wrong last word keeps lock
        send_key(32'hC);
        bus_r(1, v); chk("R2 wrong last word", v, 32'h40);
        // R2 restart on first key value, then R1 unlock
        bus_w(0, 32'h0); bus_w(0, 32'h4); bus_w(0, 32'h0);
        bus_w(0, 32'h4); bus_w(0, 32'hB); bus_w(0, 32'h2); bus_w(0, 32'h7); bus_w(0, 32'hD);
        bus_r(1, v); chk("R1 R2 unlocked after restart", v, 32'hC0);
        // R4 window closed while bit 4 clear
        bus_w(2, 0); bus_w(3, 32'h8); bus_w(4, 32'h1234);
        bus_w(1, 32'h10);
        bus_r(4, v); chk("R4 write dropped while closed", v, 0);
        // R5 indirect store / load
        bus_w(4, 32'hCAFE_F00D);
        bus_r(4, v); chk("R5 data readback", v, 32'hCAFE_F00D);
        bus_w(3, 32'h3C); bus_w(4, 32'h5555_AAAA);
        bus_w(3, 32'hB);
        bus_r(4, v); chk("R5 byte bits ignored", v, 32'hCAFE_F00D);
        bus_w(3, 32'h100);
        bus_r(4, v); chk("R5 out of range low", v, 0);
        bus_w(2, 1); bus_w(3, 32'h3C);
        bus_r(4, v); chk("R5 nonzero high word", v, 0);
        bus_w(2, 0);
        bus_r(4, v); chk("R5 last word", v, 32'h5555_AAAA);
        bus_r(3, v); chk("R9 addr low readback", v, 32'h3C);
        bus_r(0, v); chk("R9 key reads zero", v, 0);
        @(negedge clk); chk("R9 rdata holds", rdata, 0);
        // R7 boot controls
        bus_w(1, 32'h0A12);
        chk("R7 hold out", 32'(hold), 1);
        chk("R7 boot out", 32'(boot), 1);
        chk("R7 force out", 32'(force_hb), 1);
        bus_r(1, v); chk("R7 diag fields", v, 32'hBD2);
        // R8 flash-bad clear
        bus_w(1, 32'h0410);
        bus_r(1, v); chk("R8 flash cleared", v, 32'h90);
        bus_w(1, 32'h0030);
        bus_r(1, v); chk("R8 stays clear, hist written", v, 32'hB0);
        // R6 adapter reset
        bus_w(1, 32'h0014);
        n = 0;
        while (arst && n < 100) begin n++; @(negedge clk); end
        chk("R6 pulse length", 32'(n), RSTC);
        bus_r(1, v); chk("R6 relocked with history", v, 32'h20);
        bus_r(4, v); chk("R6 window closed", v, 0);
        bus_w(1, 32'h0002);
        chk("R6 R3 locked after reset", 32'(hold), 0);
        send_key(32'hD);
        bus_r(1, v); chk("R1 relock then unlock", v, 32'hA0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule